// File: doc/BRIEF.md
# Programmable High/Low Clock Divider Channel

This block produces one derived clock from a single parent clock. A control register holds a high-phase length, a low-phase length and a divider-on bit. A run register holds a single enable bit that can stop the output. With the divider off, the output is the parent clock itself. With the divider on, the output stays high for a programmed number of parent cycles and then low for another programmed number, so both the period and the duty cycle can be set.

Both registers are written and read through a small port that runs on the parent clock. A new configuration is taken up only where a low phase ends, so a reprogramming step never cuts a high or low phase short. Stopping the channel takes effect at that same point, and the stopped output rests low.

A build parameter removes the run control, for a channel that must always be running. On such a channel, writes to the run register change nothing and it always reads back as running.

Top module: `clkdiv_channel`

## Requirements
- R1: After reset the control register reads 0 (divider off, both lengths 0), the run register reads 1, and the output follows the parent clock.
- R2: While the divider-on bit (control bit 31) is 0 and the channel runs, the output is high while the parent clock is high and low while it is low.
- R3: While the divider is on, the output stays high for H+1 parent cycles and then low for L+1 parent cycles, and this repeats. H is control bits 23:16 and L is control bits 7:0.
- R4: The register at address 0 is the control word. The register at address 1 is the run register, with its enable in bit 0. A write sets the register that the write address selects.
- R5: Lengths of 0 give one parent cycle per phase, so the output toggles on every parent cycle, which is division by 2.
- R6: A new configuration written during a high phase does not change that high phase or the low phase after it. It takes effect from the next high phase.
- R7: Clearing the run bit makes the output stay low from the next phase boundary on. Setting it again restarts the programmed waveform.
- R8: On a channel built without run control, run-register writes are ignored, the register reads 1, and the output keeps running.
- R9: Reads return the last written field values, and all unused bits read 0.
- R10: An even ratio N, set by writing N/2-1 into both lengths, gives N/2 high cycles and N/2 low cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 control, 1 run |
| wr_data | input | 32 | Write data |
| rd_addr | input | 1 | Read target: 0 control, 1 run |
| rd_data | output | 32 | Read data for rd_addr, combinational |
| clk_out | output | 1 | Derived clock |

## Verification
The divider is driven with the minimum lengths (0/0), with asymmetric pairs, with an even ratio written through the halving rule, and with seeded random pairs from 0 to 7. Each run length is measured separately, so swapped fields or an off-by-one in one phase are told apart from a wrong total period. A reconfiguration lands mid-high-phase to separate deferred take-up from immediate take-up. Bypass is sampled at both parent clock levels, which tells passthrough from a stuck or divided output. Run-bit writes go to both a gated and an ungated build, which tells an honoured stop from an ignored one.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
    parameter int FIELD_W = 8;

    typedef logic [FIELD_W-1:0] phase_len_t;

    typedef struct packed {
        logic       div_on;
        phase_len_t hi_len;
        phase_len_t lo_len;
        logic       run;
    } chan_cfg_t;

    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_RUN  = 1'b1
    } reg_sel_e;

    localparam chan_cfg_t CFG_RESET = '{div_on: 1'b0, hi_len: '0, lo_len: '0, run: 1'b1};
endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
    import clkdiv_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int LO_POS   = 0,
    parameter int HI_POS   = 16,
    parameter int EN_POS   = 31,
    parameter int RUN_POS  = 0,
    parameter bit HAS_GATE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output chan_cfg_t         cfg
);
    chan_cfg_t cfg_d, cfg_q;
    logic      run_wr;

    generate
        if (HAS_GATE) begin : g_gated
            assign run_wr = wr_data[RUN_POS];
        end else begin : g_always_on
            assign run_wr = 1'b1;
        end
    endgenerate

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            if (reg_sel_e'(wr_addr) == SEL_CTRL) begin
                cfg_d.div_on = wr_data[EN_POS];
                cfg_d.hi_len = wr_data[HI_POS +: FIELD_W];
                cfg_d.lo_len = wr_data[LO_POS +: FIELD_W];
            end else begin
                cfg_d.run = run_wr;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RESET;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rd_data = '0;
        if (reg_sel_e'(rd_addr) == SEL_CTRL) begin
            rd_data[EN_POS]             = cfg_q.div_on;
            rd_data[HI_POS +: FIELD_W]  = cfg_q.hi_len;
            rd_data[LO_POS +: FIELD_W]  = cfg_q.lo_len;
        end else begin
            rd_data[RUN_POS] = cfg_q.run;
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/clkdiv_phase.sv
module clkdiv_phase
    import clkdiv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  chan_cfg_t  cfg_in,
    output chan_cfg_t  act,
    output logic       phase_hi,
    output phase_len_t cnt
);
    typedef struct packed {
        chan_cfg_t  act;
        logic       phase_hi;
        phase_len_t cnt;
    } eng_t;

    eng_t st_d, st_q;
    logic at_edge;

    always_comb begin
        st_d    = st_q;
        // a boundary is every cycle in bypass, else the last low cycle
        at_edge = !st_q.act.div_on || (!st_q.phase_hi && st_q.cnt == st_q.act.lo_len);
        if (at_edge) begin
            st_d.act      = cfg_in;
            st_d.phase_hi = 1'b1;
            st_d.cnt      = '0;
        end else if (st_q.phase_hi && st_q.cnt == st_q.act.hi_len) begin
            st_d.phase_hi = 1'b0;
            st_d.cnt      = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{act: CFG_RESET, phase_hi: 1'b1, cnt: '0};
        else        st_q <= st_d;
    end

    assign act      = st_q.act;
    assign phase_hi = st_q.phase_hi;
    assign cnt      = st_q.cnt;
endmodule

// File: rtl/clkdiv_outsel.sv
module clkdiv_outsel (
    input  logic parent_clk,
    input  logic div_on,
    input  logic run,
    input  logic phase_hi,
    output logic clk_out
);
    always_comb begin
        clk_out = run & (div_on ? phase_hi : parent_clk);
    end
endmodule

// File: rtl/clkdiv_channel.sv
module clkdiv_channel
    import clkdiv_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int LO_POS   = 0,
    parameter int HI_POS   = 16,
    parameter int EN_POS   = 31,
    parameter int RUN_POS  = 0,
    parameter bit HAS_GATE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              clk_out
);
    chan_cfg_t  reg_cfg;
    chan_cfg_t  act_cfg;
    logic       phase_hi;
    phase_len_t phase_cnt;

    clkdiv_regs #(
        .DATA_W(DATA_W), .LO_POS(LO_POS), .HI_POS(HI_POS),
        .EN_POS(EN_POS), .RUN_POS(RUN_POS), .HAS_GATE(HAS_GATE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .cfg(reg_cfg)
    );

    clkdiv_phase u_phase (
        .clk(clk), .rst_n(rst_n), .cfg_in(reg_cfg),
        .act(act_cfg), .phase_hi(phase_hi), .cnt(phase_cnt)
    );

    clkdiv_outsel u_out (
        .parent_clk(clk), .div_on(act_cfg.div_on), .run(act_cfg.run),
        .phase_hi(phase_hi), .clk_out(clk_out)
    );
endmodule

// File: rtl/clkdiv_checker.sv
module clkdiv_checker
    import clkdiv_pkg::*;
#(
    parameter bit HAS_GATE = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input chan_cfg_t  reg_cfg,
    input chan_cfg_t  act_cfg,
    input logic       phase_hi,
    input phase_len_t phase_cnt
);
    // R3: the counter never passes the length of the phase it is in
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (act_cfg.div_on && phase_hi) |-> (phase_cnt <= act_cfg.hi_len));

    assert_lo_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (act_cfg.div_on && !phase_hi) |-> (phase_cnt <= act_cfg.lo_len));

    // R3: a high phase ends only after its full programmed length
    assert_high_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phase_hi) |-> ($past(phase_cnt) == $past(act_cfg.hi_len)));

    // R6: the active setting holds everywhere except at the end of a low phase
    assert_no_midphase_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (act_cfg.div_on && !(!phase_hi && phase_cnt == act_cfg.lo_len)) |=> $stable(act_cfg));

    // R2: bypass keeps the engine parked at the start of a high phase
    assert_bypass_park_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !act_cfg.div_on |=> (phase_hi && phase_cnt == '0));

    generate
        if (!HAS_GATE) begin : g_ng
            // R8: an always-on channel never holds a cleared run bit
            assert_always_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
                reg_cfg.run && act_cfg.run);
        end
    endgenerate
endmodule

bind clkdiv_channel clkdiv_checker #(.HAS_GATE(HAS_GATE)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_cfg(reg_cfg), .act_cfg(act_cfg),
    .phase_hi(phase_hi), .phase_cnt(phase_cnt)
);

// File: tb/tb_clkdiv_channel.sv
`timescale 1ns/1ps
module tb_clkdiv_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_addr = 1'b0, rd_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data, ng_rd_data;
    logic        clk_out, ng_out;
    logic        ng_wr_en = 1'b0;
    int          n_vec = 0, n_bad = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    clkdiv_channel dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .clk_out(clk_out));

    clkdiv_channel #(.HAS_GATE(1'b0)) dut_ng (.clk(clk), .rst_n(rst_n), .wr_en(ng_wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(ng_rd_data),
        .clk_out(ng_out));

    function automatic logic [31:0] ctrl_word(bit en, int hi, int lo);
        return {en, 7'd0, 8'(hi), 8'd0, 8'(lo)};
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_now(bit sel, bit addr, logic [31:0] d);
        wr_addr = addr; wr_data = d;
        if (sel) ng_wr_en = 1'b1; else wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; ng_wr_en = 1'b0;
    endtask

    task automatic wr(bit sel, bit addr, logic [31:0] d);
        @(negedge clk);
        wr_now(sel, addr, d);
    endtask

    task automatic rd(bit sel, bit addr, output logic [31:0] d);
        rd_addr = addr; #1;
        d = sel ? ng_rd_data : rd_data;
    endtask

    task automatic samp(bit sel, output bit v);
        @(negedge clk); #1;
        v = sel ? ng_out : clk_out;
    endtask

    task automatic sync_rise(bit sel);
        bit p, c;
        samp(sel, p);
        for (int i = 0; i < 3000; i++) begin
            samp(sel, c);
            if (!p && c) return;
            p = c;
        end
    endtask

    task automatic count_run(bit sel, bit v, output int n);
        bit c;
        n = 0;
        c = sel ? ng_out : clk_out;
        while (c == v && n < 3000) begin
            n++;
            samp(sel, c);
        end
    endtask

    task automatic measure(bit sel, output int h, output int l);
        sync_rise(sel);
        count_run(sel, 1'b1, h);
        count_run(sel, 1'b0, l);
    endtask

    task automatic settle_measure(bit sel, output int h, output int l);
        int dh, dl;
        measure(sel, dh, dl);
        measure(sel, h, l);
    endtask

    task automatic check_bypass(string req, bit exp_hi);
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #2;
            check(clk_out == exp_hi, req, clk_out, exp_hi);
            @(negedge clk); #2;
            check(clk_out == 1'b0, req, clk_out, 0);
        end
    endtask

    task automatic div_case(string req, int hi, int lo);
        int h, l;
        wr(0, 0, ctrl_word(1, hi, lo));
        settle_measure(0, h, l);
        check(h == hi + 1, req, h, hi + 1);
        check(l == lo + 1, req, l, lo + 1);
    endtask

    initial begin
        for (int i = 0; i < 150000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int h, l, hh, ll, cnt;
        bit c;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(0, 0, d); check(d == 32'd0, "R1", d, 0);
        rd(0, 1, d); check(d == 32'd1, "R1", d, 1);
        check_bypass("R1", 1'b1);

        // R5 minimum division
        div_case("R5", 0, 0);
        // R3 asymmetric patterns
        div_case("R3", 3, 1);
        div_case("R3", 0, 4);
        // R10 even ratio 6 -> fields 2/2
        div_case("R10", 6/2 - 1, 6/2 - 1);
        // R3 random lengths
        for (int k = 0; k < 6; k++) begin
            int rh, rl;
            rh = int'($urandom_range(0, 7));
            rl = int'($urandom_range(0, 7));
            div_case("R3", rh, rl);
        end

        // R4/R9 readback of field positions
        wr(0, 0, ctrl_word(1, 9, 4));
        rd(0, 0, d); check(d == 32'h8009_0004, "R4", d, 32'h8009_0004);

        // R6 change during a high phase
        wr(0, 0, ctrl_word(1, 5, 5));
        settle_measure(0, h, l);
        sync_rise(0);
        fork wr_now(0, 0, ctrl_word(1, 1, 2)); join_none
        count_run(0, 1'b1, h);
        count_run(0, 1'b0, l);
        count_run(0, 1'b1, hh);
        count_run(0, 1'b0, ll);
        check(h == 6, "R6", h, 6);
        check(l == 6, "R6", l, 6);
        check(hh == 2, "R6", hh, 2);
        check(ll == 3, "R6", ll, 3);

        // R7 stop then restart
        wr(0, 1, 32'd0);
        repeat (12) @(negedge clk);
        cnt = 0;
        for (int i = 0; i < 30; i++) begin samp(0, c); cnt += c; end
        check(cnt == 0, "R7", cnt, 0);
        rd(0, 1, d); check(d == 32'd0, "R7", d, 0);
        wr(0, 1, 32'd1);
        settle_measure(0, h, l);
        check(h == 2 && l == 3, "R7", h * 10 + l, 23);

        // R2 back to bypass
        wr(0, 0, ctrl_word(0, 1, 2));
        repeat (10) @(negedge clk);
        check_bypass("R2", 1'b1);
        wr(0, 1, 32'd0);
        repeat (3) @(negedge clk);
        check_bypass("R2", 1'b0);
        wr(0, 1, 32'd1);

        // R9 reserved bits read 0
        wr(0, 0, 32'hFFFF_FFFF);
        rd(0, 0, d); check(d == 32'h80FF_00FF, "R9", d, 32'h80FF_00FF);
        wr(0, 1, 32'hFFFF_FFFE);
        rd(0, 1, d); check(d == 32'd0, "R9", d, 0);
        wr(0, 1, 32'hFFFF_FFFF);
        rd(0, 1, d); check(d == 32'd1, "R9", d, 1);

        // R8 always-on channel ignores stop
        wr(1, 0, ctrl_word(1, 1, 1));
        wr(1, 1, 32'd0);
        rd(1, 1, d); check(d == 32'd1, "R8", d, 1);
        repeat (12) @(negedge clk);
        cnt = 0;
        for (int i = 0; i < 20; i++) begin samp(1, c); cnt += c; end
        check(cnt == 10, "R8", cnt, 10);
        settle_measure(1, h, l);
        check(h == 2 && l == 2, "R8", h * 10 + l, 22);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule